// File: doc/BRIEF.md
# Exception Frame Push/Pop Sequencer

This block performs the hardware register save that a 32-bit core makes when it takes an exception, and the matching restore when the handler returns. On an entry request it picks the stack that was in use just before the exception. That is the process pointer when the core was in thread mode with the stack-select bit set, and the main pointer in every other case. It then writes the eight-word frame onto that stack, which grows downward, one word at a time. It can skip one extra word first so that the frame lands on an 8-byte boundary. When it finishes, the core is in handler mode on the main pointer, and the pointer that was used has moved down past the frame.

On a return request the block looks at the low nibble of the return code. That nibble alone picks the target: handler mode on the main pointer, thread mode on the main pointer, or thread mode on the process pointer. The block reads the eight words back from the chosen stack, lowest address first, and presents them as restored registers. A flag bit inside the restored status word says whether an alignment word was skipped, and the pointer is raised past it if so. An undefined code raises an error pulse and touches nothing.

Memory is a single-word request/ready handshake. A request and its address, direction and write data stay stable until ready is seen high at a clock edge.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset, mem_req, busy, done and ret_err are low, and msp_out, psp_out, handler_mode and spsel_out are zero.
- R2: On entry the frame goes to the process pointer when in_handler=0 and spsel_in=1, and to the main pointer otherwise.
- R3: An entry issues exactly eight writes at descending word addresses, 4 bytes apart. The words go out in this order: save_regs index 7 (status word), 6 (PC), 5 (LR), 4 (R12), 3, 2, 1, 0 (R0).
- R4: When align_en=1 and bit 2 of the chosen pointer is 1, the first write goes to pointer-8 and bit 9 of the written status word is 1. Otherwise the first write goes to pointer-4 and bit 9 of the status word is 0. All other status bits are written unchanged.
- R5: After an entry the used pointer output equals the old pointer minus 32, or minus 36 with padding. The other pointer output equals its input at the request. handler_mode=1 and spsel_out=0.
- R6: While mem_req is high and mem_ready is low, mem_req, mem_addr, mem_we and mem_wdata hold their values into the next cycle.
- R7: done is high for exactly one cycle, the cycle after the last transfer's handshake, and the pointer and mode outputs take their new values in that same cycle.
- R8: A return code whose low nibble is 0x1 restores handler mode with the main pointer. A nibble of 0x9 restores thread mode with the main pointer. A nibble of 0xD restores thread mode with the process pointer (spsel_out=1). Only 0xD reads from psp_in; the other two read from msp_in.
- R9: A return issues eight reads at ascending addresses starting at the chosen pointer. The word at offset 4*k appears in restore_regs index k. The chosen pointer output becomes the pointer plus 32, or plus 36 when bit 9 of the word read at offset 28 is 1.
- R10: A return code with any other low nibble gives a one-cycle ret_err pulse in the next cycle. It causes no memory transfer and leaves the pointer and mode outputs unchanged.
- R11: entry_req and ret_req are ignored while busy is high. When both are raised together in idle, the entry is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_req | input | 1 | Start a frame save (sampled when idle) |
| in_handler | input | 1 | Core is in handler mode at entry |
| spsel_in | input | 1 | Stack-select bit at entry |
| align_en | input | 1 | Enable 8-byte frame alignment |
| msp_in | input | 32 | Current main stack pointer |
| psp_in | input | 32 | Current process stack pointer |
| save_regs | input | 8x32 | Words to save: 0=R0,1=R1,2=R2,3=R3,4=R12,5=LR,6=PC,7=status |
| ret_req | input | 1 | Start a frame restore (sampled when idle) |
| ret_code | input | 32 | Return code; the low nibble selects the target |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Transfer completes at this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| ret_err | output | 1 | One-cycle undefined-return-code pulse |
| msp_out | output | 32 | Main stack pointer after the last sequence |
| psp_out | output | 32 | Process stack pointer after the last sequence |
| handler_mode | output | 1 | 1 = handler mode after the last sequence |
| spsel_out | output | 1 | Stack-select bit after the last sequence |
| restore_regs | output | 8x32 | Words read by the last return |

## Verification
The assertions check every cycle that a stalled request stays stable, that write addresses step down and read addresses step up by one word per beat, that done never lasts two cycles, that an error pulse never comes with memory activity, and that every completed save leaves handler mode on the main stack. Only the directed scenarios can show which stack gets the frame and how padding depends on alignment. They also cover the exact word order and status flag in memory, the pointer arithmetic on both paths, the three return targets, and that requests arriving during a sequence are dropped.

// File: rtl/exc_frame_pkg.sv
// Shared types and constants for the exception frame sequencer.
// Assumes a 32-bit core whose return codes are decoded on the low nibble.
package exc_frame_pkg;

    // Engine sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2
    } eng_state_e;

    // Decoded target of a return code
    typedef struct packed {
        logic valid;
        logic to_handler;
        logic to_psp;
    } ret_target_t;

    // Low-nibble encodings of the three defined return codes
    localparam logic [3:0] RC_HANDLER_MAIN = 4'h1;
    localparam logic [3:0] RC_THREAD_MAIN  = 4'h9;
    localparam logic [3:0] RC_THREAD_PROC  = 4'hD;

endpackage

// File: rtl/exc_ret_decode.sv
// Return-code decoder. Looks only at the low nibble of the code and
// yields the target mode, stack and a valid flag. Purely combinational.
module exc_ret_decode
    import exc_frame_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] code,
    output ret_target_t       target
);

    // Map the three legal nibbles onto mode/stack; everything else is invalid
    always_comb begin
        target = '0;
        unique case (code[3:0])
            RC_HANDLER_MAIN: target = '{valid: 1'b1, to_handler: 1'b1, to_psp: 1'b0};
            RC_THREAD_MAIN:  target = '{valid: 1'b1, to_handler: 1'b0, to_psp: 1'b0};
            RC_THREAD_PROC:  target = '{valid: 1'b1, to_handler: 1'b0, to_psp: 1'b1};
            default:         target = '0;
        endcase
    end

endmodule

// File: rtl/exc_stack_pick.sv
// Entry-side stack chooser. Chooses the pointer that was live before the
// exception and decides if one word of padding is needed for 8-byte
// alignment. Assumes pointers are always word aligned.
module exc_stack_pick #(
    parameter int DATA_W = 32
) (
    input  logic              in_handler,
    input  logic              spsel,
    input  logic              align_en,
    input  logic [DATA_W-1:0] msp,
    input  logic [DATA_W-1:0] psp,
    output logic              use_psp,
    output logic [DATA_W-1:0] sp_sel,
    output logic              pad_need
);

    localparam int BYTES     = DATA_W / 8;
    localparam int ALIGN_BIT = $clog2(BYTES);

    // Process stack only for thread mode with the select bit set
    always_comb begin
        use_psp  = !in_handler && spsel;
        sp_sel   = use_psp ? psp : msp;
        pad_need = align_en && sp_sel[ALIGN_BIT];
    end

endmodule

// File: rtl/exc_frame_engine.sv
// Word-by-word frame mover. In push mode it writes FRAME_WORDS words from
// the highest index down at descending addresses; in pop mode it reads
// them back at ascending addresses. Every beat waits for mem_ready.
// fin marks the handshake of the last beat; fin_sp is the pointer value
// the caller should adopt at that edge.
module exc_frame_engine
    import exc_frame_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FRAME_WORDS = 8,
    parameter int PAD_BIT     = 9
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_push,
    input  logic                                start_pop,
    input  logic [DATA_W-1:0]                   push_sp,
    input  logic                                push_pad,
    input  logic [FRAME_WORDS-1:0][DATA_W-1:0]  push_regs,
    input  logic [DATA_W-1:0]                   pop_sp,
    input  logic                                mem_ready,
    input  logic [DATA_W-1:0]                   mem_rdata,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [DATA_W-1:0]                   mem_addr,
    output logic [DATA_W-1:0]                   mem_wdata,
    output logic                                busy,
    output logic                                fin,
    output logic [DATA_W-1:0]                   fin_sp,
    output logic [FRAME_WORDS-1:0][DATA_W-1:0]  pop_regs
);

    localparam int                CNT_W = $clog2(FRAME_WORDS);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(FRAME_WORDS - 1);
    localparam logic [DATA_W-1:0] STEP  = DATA_W'(DATA_W / 8);

    eng_state_e                        state_q;
    logic [CNT_W-1:0]                  cnt_q;
    logic [DATA_W-1:0]                 addr_q;
    logic [FRAME_WORDS-1:0][DATA_W-1:0] wr_regs_q;
    logic [FRAME_WORDS-1:0][DATA_W-1:0] frame_in;
    logic                              beat;
    logic                              last;

    // Status word carries the padding flag in the frame
    always_comb begin
        frame_in = push_regs;
        frame_in[FRAME_WORDS-1][PAD_BIT] = push_pad;
    end

    // Bus outputs follow the state and registered address
    always_comb begin
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_PUSH);
        mem_addr  = addr_q;
        mem_wdata = wr_regs_q[LAST - cnt_q];
        busy      = mem_req;
        beat      = mem_req && mem_ready;
        last      = (cnt_q == LAST);
        fin       = beat && last;
    end

    // Pointer left behind by the finishing beat
    always_comb begin
        if (state_q == ST_PUSH) begin
            fin_sp = addr_q;
        end else begin
            fin_sp = addr_q + STEP + (mem_rdata[PAD_BIT] ? STEP : '0);
        end
    end

    // Sequencing: start, step per accepted beat, return to idle after last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            addr_q    <= '0;
            wr_regs_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start_push) begin
                        state_q   <= ST_PUSH;
                        addr_q    <= push_sp - STEP - (push_pad ? STEP : '0);
                        wr_regs_q <= frame_in;
                    end else if (start_pop) begin
                        state_q <= ST_POP;
                        addr_q  <= pop_sp;
                    end
                end
                ST_PUSH: begin
                    if (beat) begin
                        cnt_q  <= cnt_q + 1'b1;
                        addr_q <= addr_q - STEP;
                        if (last) state_q <= ST_IDLE;
                    end
                end
                ST_POP: begin
                    if (beat) begin
                        cnt_q  <= cnt_q + 1'b1;
                        addr_q <= addr_q + STEP;
                        if (last) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture read words into their frame slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_regs <= '0;
        end else if (state_q == ST_POP && beat) begin
            pop_regs[cnt_q] <= mem_rdata;
        end
    end

endmodule

// File: rtl/exc_frame_seq.sv
// Exception frame sequencer top. Accepts entry and return requests while
// idle, drives the frame engine, and owns the resulting pointer and mode
// state. Assumes both input pointers are word aligned and the return code
// is presented with ret_req.
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FRAME_WORDS = 8,
    parameter int PAD_BIT     = 9
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               entry_req,
    input  logic                               in_handler,
    input  logic                               spsel_in,
    input  logic                               align_en,
    input  logic [DATA_W-1:0]                  msp_in,
    input  logic [DATA_W-1:0]                  psp_in,
    input  logic [FRAME_WORDS-1:0][DATA_W-1:0] save_regs,
    input  logic                               ret_req,
    input  logic [DATA_W-1:0]                  ret_code,
    output logic                               mem_req,
    output logic                               mem_we,
    output logic [DATA_W-1:0]                  mem_addr,
    output logic [DATA_W-1:0]                  mem_wdata,
    input  logic                               mem_ready,
    input  logic [DATA_W-1:0]                  mem_rdata,
    output logic                               busy,
    output logic                               done,
    output logic                               ret_err,
    output logic [DATA_W-1:0]                  msp_out,
    output logic [DATA_W-1:0]                  psp_out,
    output logic                               handler_mode,
    output logic                               spsel_out,
    output logic [FRAME_WORDS-1:0][DATA_W-1:0] restore_regs
);

    ret_target_t        tgt;
    logic               use_psp;
    logic [DATA_W-1:0]  sp_sel;
    logic               pad_need;
    logic               go_entry;
    logic               go_ret;
    logic               bad_ret;
    logic               fin;
    logic [DATA_W-1:0]  fin_sp;

    logic               tgt_psp_q;
    logic               tgt_handler_q;
    logic               tgt_spsel_q;
    logic [DATA_W-1:0]  msp_q;
    logic [DATA_W-1:0]  psp_q;
    logic               handler_q;
    logic               spsel_q;
    logic               done_q;
    logic               err_q;

    exc_ret_decode #(.DATA_W(DATA_W)) dec_i (
        .code   (ret_code),
        .target (tgt)
    );

    exc_stack_pick #(.DATA_W(DATA_W)) pick_i (
        .in_handler (in_handler),
        .spsel      (spsel_in),
        .align_en   (align_en),
        .msp        (msp_in),
        .psp        (psp_in),
        .use_psp    (use_psp),
        .sp_sel     (sp_sel),
        .pad_need   (pad_need)
    );

    // Request arbitration: only when idle, entry before return
    always_comb begin
        go_entry = !busy && entry_req;
        go_ret   = !busy && !entry_req && ret_req && tgt.valid;
        bad_ret  = !busy && !entry_req && ret_req && !tgt.valid;
    end

    exc_frame_engine #(
        .DATA_W      (DATA_W),
        .FRAME_WORDS (FRAME_WORDS),
        .PAD_BIT     (PAD_BIT)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_push (go_entry),
        .start_pop  (go_ret),
        .push_sp    (sp_sel),
        .push_pad   (pad_need),
        .push_regs  (save_regs),
        .pop_sp     (tgt.to_psp ? psp_in : msp_in),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .fin        (fin),
        .fin_sp     (fin_sp),
        .pop_regs   (restore_regs)
    );

    // Latch the destination of a sequence and both starting pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_psp_q     <= 1'b0;
            tgt_handler_q <= 1'b0;
            tgt_spsel_q   <= 1'b0;
        end else if (go_entry) begin
            tgt_psp_q     <= use_psp;
            tgt_handler_q <= 1'b1;
            tgt_spsel_q   <= 1'b0;
        end else if (go_ret) begin
            tgt_psp_q     <= tgt.to_psp;
            tgt_handler_q <= tgt.to_handler;
            tgt_spsel_q   <= tgt.to_psp;
        end
    end

    // Pointer and mode state: load at start, commit on the final beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msp_q     <= '0;
            psp_q     <= '0;
            handler_q <= 1'b0;
            spsel_q   <= 1'b0;
        end else if (go_entry || go_ret) begin
            msp_q <= msp_in;
            psp_q <= psp_in;
        end else if (fin) begin
            if (tgt_psp_q) psp_q <= fin_sp;
            else           msp_q <= fin_sp;
            handler_q <= tgt_handler_q;
            spsel_q   <= tgt_spsel_q;
        end
    end

    // One-cycle completion and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= fin;
            err_q  <= bad_ret;
        end
    end

    assign done         = done_q;
    assign ret_err      = err_q;
    assign handler_mode = handler_q;
    assign spsel_out    = spsel_q;

    // Pointer outputs show the committed values once no sequence is pending
    logic [DATA_W-1:0] msp_shown_q;
    logic [DATA_W-1:0] psp_shown_q;

    // Expose pointers only at completion so they never show half-updated state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msp_shown_q <= '0;
            psp_shown_q <= '0;
        end else if (fin) begin
            msp_shown_q <= tgt_psp_q ? msp_q : fin_sp;
            psp_shown_q <= tgt_psp_q ? fin_sp : psp_q;
        end
    end

    assign msp_out = msp_shown_q;
    assign psp_out = psp_shown_q;

endmodule

// File: rtl/exc_frame_seq_chk.sv
// Protocol and sequencing checker for exc_frame_seq, bound to the top.
module exc_frame_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              done,
    input logic              ret_err,
    input logic              handler_mode,
    input logic              spsel_out
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

    // R6: a stalled request holds everything it presents
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R3: successive writes step one word down
    p_push_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ready |=> !mem_req || (mem_we && mem_addr == $past(mem_addr) - STEP));

    // R3: word-aligned transfer addresses
    p_word_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R9: successive reads step one word up
    p_pop_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |=> !mem_req || (!mem_we && mem_addr == $past(mem_addr) + STEP));

    // R7: done never lasts two cycles
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done follows an accepted transfer
    p_done_after_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_ready));

    // R10: an error pulse comes with no bus activity and no completion
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_err |-> !mem_req && !done);

    // R5: a completed save leaves handler mode on the main stack
    p_entry_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(mem_we) |-> handler_mode && !spsel_out);

endmodule

bind exc_frame_seq exc_frame_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ready    (mem_ready),
    .done         (done),
    .ret_err      (ret_err),
    .handler_mode (handler_mode),
    .spsel_out    (spsel_out)
);

// File: tb/exc_frame_seq_tb_top.sv
// Directed bench for exc_frame_seq with a word memory model and stalls.
module exc_frame_seq_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              entry_req = 1'b0;
    logic              in_handler = 1'b0;
    logic              spsel_in = 1'b0;
    logic              align_en = 1'b0;
    logic [31:0]       msp_in = '0;
    logic [31:0]       psp_in = '0;
    logic [7:0][31:0]  save_regs = '0;
    logic              ret_req = 1'b0;
    logic [31:0]       ret_code = '0;
    logic              mem_req;
    logic              mem_we;
    logic [31:0]       mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_ready;
    logic [31:0]       mem_rdata;
    logic              busy;
    logic              done;
    logic              ret_err;
    logic [31:0]       msp_out;
    logic [31:0]       psp_out;
    logic              handler_mode;
    logic              spsel_out;
    logic [7:0][31:0]  restore_regs;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem [0:255];
    logic [31:0] wr_addr [0:15];
    logic [31:0] wr_data [0:15];
    int          wr_n = 0;
    int          rd_n = 0;
    logic        stall = 1'b0;
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'h5A;
    logic        hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [31:0] hold_data = '0;
    int          hold_err = 0;

    always #5 clk = ~clk;

    exc_frame_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_req    (entry_req),
        .in_handler   (in_handler),
        .spsel_in     (spsel_in),
        .align_en     (align_en),
        .msp_in       (msp_in),
        .psp_in       (psp_in),
        .save_regs    (save_regs),
        .ret_req      (ret_req),
        .ret_code     (ret_code),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .done         (done),
        .ret_err      (ret_err),
        .msp_out      (msp_out),
        .psp_out      (psp_out),
        .handler_mode (handler_mode),
        .spsel_out    (spsel_out),
        .restore_regs (restore_regs)
    );

    assign mem_ready = mem_req && !stall;
    assign mem_rdata = mem[mem_addr[9:2]];

    // Memory model, transfer log, stall generator and stall-hold monitor
    always @(posedge clk) begin
        cycles <= cycles + 1;
        lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        stall  <= stall_en && lfsr[0];
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                if (wr_n < 16) begin
                    wr_addr[wr_n] <= mem_addr;
                    wr_data[wr_n] <= mem_wdata;
                end
                wr_n <= wr_n + 1;
            end else begin
                rd_n <= rd_n + 1;
            end
        end
        if (hold_pend && (!mem_req || mem_addr != hold_addr || mem_wdata != hold_data))
            hold_err <= hold_err + 1;
        hold_pend <= mem_req && !mem_ready;
        hold_addr <= mem_addr;
        hold_data <= mem_wdata;
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk({req, " done seen"}, 32'(done), 32'd1);
    endtask

    task automatic clear_log();
        @(negedge clk);
        wr_n = 0;
        rd_n = 0;
    endtask

    // R1: reset values
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 ret_err", 32'(ret_err), 0);
        chk("R1 msp_out", msp_out, 0);
        chk("R1 psp_out", psp_out, 0);
        chk("R1 mode", {30'd0, handler_mode, spsel_out}, 0);
    endtask

    // R2 R3 R4 R5 R7: one entry with computed expectations
    task automatic t_entry(input logic h, input logic s, input logic al,
                           input logic [31:0] m, input logic [31:0] p, input logic [31:0] seed);
        logic [31:0] sp, top, x;
        logic pad, upsp;
        clear_log();
        for (int i = 0; i < 8; i++) save_regs[i] = seed + 32'(i * 32'h111) ;
        save_regs[7][9] = ~save_regs[7][9];
        in_handler = h; spsel_in = s; align_en = al; msp_in = m; psp_in = p;
        upsp = !h && s;
        sp   = upsp ? p : m;
        pad  = al && sp[2];
        top  = sp - 32'd4 - (pad ? 32'd4 : 32'd0);
        entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        wait_done("R7 entry");
        chk("R3 write count", 32'(wr_n), 8);
        for (int k = 0; k < 8; k++) begin
            x = save_regs[7 - k];
            if (k == 0) x[9] = pad;
            chk("R3 R4 write addr", wr_addr[k], top - 32'(4 * k));
            chk("R3 R4 write data", wr_data[k], x);
        end
        chk("R2 R5 used ptr", upsp ? psp_out : msp_out, sp - 32'd32 - (pad ? 32'd4 : 32'd0));
        chk("R2 R5 other ptr", upsp ? msp_out : psp_out, upsp ? m : p);
        chk("R5 handler", 32'(handler_mode), 1);
        chk("R5 spsel", 32'(spsel_out), 0);
        @(negedge clk);
        chk("R7 done one cycle", 32'(done), 0);
    endtask

    // R8 R9: one return with the frame preloaded in the memory model
    task automatic t_return(input logic [3:0] nib, input logic pad,
                            input logic [31:0] m, input logic [31:0] p, input logic [31:0] seed);
        logic [31:0] sp, w;
        logic upsp;
        clear_log();
        upsp = (nib == 4'hD);
        sp   = upsp ? p : m;
        for (int k = 0; k < 8; k++) begin
            w = seed ^ 32'(k * 32'h01010101);
            if (k == 7) w[9] = pad;
            mem[sp[9:2] + 8'(k)] = w;
        end
        msp_in = m; psp_in = p;
        ret_code = {28'hFFFFFFF, nib};
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        wait_done("R8 return");
        chk("R9 read count", 32'(rd_n), 8);
        chk("R9 no writes", 32'(wr_n), 0);
        for (int k = 0; k < 8; k++)
            chk("R9 restored word", restore_regs[k], mem[sp[9:2] + 8'(k)]);
        chk("R8 R9 used ptr", upsp ? psp_out : msp_out, sp + 32'd32 + (pad ? 32'd4 : 32'd0));
        chk("R8 other ptr", upsp ? msp_out : psp_out, upsp ? m : p);
        chk("R8 handler", 32'(handler_mode), (nib == 4'h1) ? 1 : 0);
        chk("R8 spsel", 32'(spsel_out), upsp ? 1 : 0);
    endtask

    // R10: undefined return code
    task automatic t_bad(input logic [3:0] nib);
        logic [31:0] m0, p0;
        logic h0, s0;
        clear_log();
        m0 = msp_out; p0 = psp_out; h0 = handler_mode; s0 = spsel_out;
        msp_in = 32'h340; psp_in = 32'h3A0;
        ret_code = {28'hFFFFFFF, nib};
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        chk("R10 err pulse", 32'(ret_err), 1);
        chk("R10 no request", 32'(mem_req), 0);
        @(negedge clk);
        chk("R10 err one cycle", 32'(ret_err), 0);
        repeat (3) @(negedge clk);
        chk("R10 no transfers", 32'(wr_n + rd_n), 0);
        chk("R10 msp kept", msp_out, m0);
        chk("R10 psp kept", psp_out, p0);
        chk("R10 mode kept", {30'd0, handler_mode, spsel_out}, {30'd0, h0, s0});
    endtask

    // R11: simultaneous requests and requests while busy
    task automatic t_busy();
        clear_log();
        in_handler = 1'b0; spsel_in = 1'b0; align_en = 1'b0;
        msp_in = 32'h300; psp_in = 32'h3C0;
        ret_code = 32'hFFFFFFFD;
        entry_req = 1'b1; ret_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        repeat (2) @(negedge clk);
        entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0; ret_req = 1'b0;
        wait_done("R11 entry");
        chk("R11 entry taken writes", 32'(wr_n), 8);
        chk("R11 return dropped reads", 32'(rd_n), 0);
        chk("R11 handler", 32'(handler_mode), 1);
        chk("R11 msp", msp_out, 32'h2E0);
        repeat (20) @(negedge clk);
        chk("R11 no later transfers", 32'(wr_n + rd_n), 8);
    endtask

    initial begin
        t_reset();
        t_entry(1'b0, 1'b0, 1'b1, 32'h300, 32'h3C0, 32'hA0000000);
        stall_en = 1'b1;
        t_entry(1'b0, 1'b1, 1'b1, 32'h2F0, 32'h3BC, 32'hB0000000);
        t_entry(1'b1, 1'b1, 1'b1, 32'h2FC, 32'h3C0, 32'hC0000000);
        t_entry(1'b0, 1'b1, 1'b0, 32'h300, 32'h3B4, 32'hD0000000);
        t_return(4'h1, 1'b0, 32'h280, 32'h380, 32'h12345678);
        t_return(4'h9, 1'b1, 32'h288, 32'h380, 32'h9ABCDEF0);
        t_return(4'hD, 1'b1, 32'h280, 32'h390, 32'h0F1E2D3C);
        stall_en = 1'b0;
        t_return(4'hD, 1'b0, 32'h280, 32'h3A0, 32'h55AA33CC);
        t_bad(4'h5);
        t_bad(4'h0);
        t_busy();
        chk("R6 stall hold", 32'(hold_err), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule